// File: doc/BRIEF.md
# Per-Pin Interrupt Event Detector

This block watches a bank of synchronised I/O pin values and turns selected pin activity into latched interrupt events. Each pin has three configuration bits: a sense bit, a both-edges bit and a polarity bit. Together they pick one of five detection modes: high level, low level, rising edge, falling edge or any edge. A direction bit per pin marks it as an output, and edge detection is suppressed on output pins.

Detected events are held in a raw status vector until software clears them. It clears them by pulsing a clear strobe with a ones-to-clear mask. The raw status is ANDed with a per-pin enable vector to form the masked status. Any set masked bit raises the single combined interrupt line. Bus decoding and register storage live outside the block; the configuration arrives as plain input vectors.

Top module: `pin_event_detector`

## Requirements
- R1: After reset the raw status is all zero, and no event is recorded in the first clock cycle after reset is released, even if a level condition already holds then.
- R2: A pin whose direction bit is 1 (output) never records an edge event, whatever its value does.
- R3: With sense bit 1 the pin is level sensed: its raw bit is set on a cycle where the pin value equals its polarity bit (1 = active high, 0 = active low). This applies whatever the direction bit.
- R4: With sense 0 and both-edges 1, any change of an input pin between two consecutive samples sets its raw bit, regardless of the polarity bit.
- R5: With sense 0 and both-edges 0, polarity 1 latches only 0-to-1 changes and polarity 0 latches only 1-to-0 changes.
- R6: A cycle with clear strobe high clears every raw bit whose mask bit is 1 and leaves bits whose mask bit is 0 unchanged.
- R7: A level-sensed bit is set again on every cycle its condition holds, so a clear takes effect only once the pin has left the active level.
- R8: When a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R9: The masked status is the raw status ANDed with the enable vector, and the interrupt output is 1 exactly when any masked bit is 1.
- R10: Changing a pin's sense, both-edges, polarity or enable bits leaves its latched raw bit unchanged.
- R11: A raw bit becomes visible on the outputs at the first clock edge that samples the triggering pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronised pin values |
| dir_out_i | input | NUM_PINS | Direction per pin, 1 = output |
| sense_lvl_i | input | NUM_PINS | 1 = level sensed, 0 = edge sensed |
| both_edge_i | input | NUM_PINS | 1 = any edge (edge mode only) |
| polarity_i | input | NUM_PINS | 1 = rising / active high, 0 = falling / active low |
| enable_i | input | NUM_PINS | Per-pin interrupt enable |
| clr_we_i | input | 1 | Clear strobe |
| clr_mask_i | input | NUM_PINS | Ones-to-clear mask, used while clr_we_i is 1 |
| raw_o | output | NUM_PINS | Latched raw event status |
| masked_o | output | NUM_PINS | Raw status ANDed with enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a clear that lands in exactly the cycle a new event is detected, from a known previous pin sample. The bench reaches it in one sweep. It first holds the pins at a chosen previous value, then drives the new value together with an all-ones clear. The raw status one edge later therefore equals the event term alone. This is repeated for every combination of the three configuration bits, the direction bit and the previous and new pin values. Further directed sequences cover the first cycle after reset, partial clears, clears against a held level, and configuration changes over latched bits.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  typedef enum logic [2:0] {
    DET_FALL,
    DET_RISE,
    DET_ANY,
    DET_LVL_LO,
    DET_LVL_HI
  } det_mode_e;

  function automatic det_mode_e decode_mode(logic sense, logic both, logic pol);
    if (sense)     return pol ? DET_LVL_HI : DET_LVL_LO;
    else if (both) return DET_ANY;
    else           return pol ? DET_RISE : DET_FALL;
  endfunction

endpackage

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic pin_i,
  input  logic is_out_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  output logic evt_o
);

  logic      prev_q;
  det_mode_e mode;
  logic      rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign mode = decode_mode(sense_i, both_i, pol_i);
  assign rise = !prev_q && pin_i;
  assign fall = prev_q && !pin_i;

  always_comb begin
    evt_o = 1'b0;
    if (armed_i) begin
      unique case (mode)
        DET_LVL_HI: evt_o = pin_i;
        DET_LVL_LO: evt_o = !pin_i;
        DET_ANY:    evt_o = !is_out_i && (rise || fall);
        DET_RISE:   evt_o = !is_out_i && rise;
        DET_FALL:   evt_o = !is_out_i && fall;
        default:    evt_o = 1'b0;
      endcase
    end
  end

  // R2
  out_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_out_i && !sense_i) |-> !evt_o);

  // R5
  rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i && !both_i && pol_i && evt_o) |-> (pin_i && !prev_q));

endmodule

// File: rtl/pin_evt_status.sv
module pin_evt_status #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  input  logic [NUM_PINS-1:0] enable_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] raw_q;

  for (genvar j = 0; j < NUM_PINS; j++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_we_i && clr_mask_i[j];

    // event has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_q[j] <= 1'b0;
      else if (evt_i[j]) raw_q[j] <= 1'b1;
      else if (clr_hit)  raw_q[j] <= 1'b0;
    end

    // R6
    clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_hit && !evt_i[j]) |=> !raw_q[j]);

    // R8
    evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_hit && evt_i[j]) |=> raw_q[j]);

    // R10
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_q[j] && !clr_hit) |=> raw_q[j]);
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & enable_i;
  assign irq_o    = |masked_o;

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] dir_out_i,
  input  logic [NUM_PINS-1:0] sense_lvl_i,
  input  logic [NUM_PINS-1:0] both_edge_i,
  input  logic [NUM_PINS-1:0] polarity_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);

  logic                armed_q;
  logic [NUM_PINS-1:0] evt;

  // previous samples are invalid until one clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_evt_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .armed_i  (armed_q),
      .pin_i    (pin_i[p]),
      .is_out_i (dir_out_i[p]),
      .sense_i  (sense_lvl_i[p]),
      .both_i   (both_edge_i[p]),
      .pol_i    (polarity_i[p]),
      .evt_o    (evt[p])
    );
  end

  pin_evt_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .enable_i   (enable_i),
    .raw_o      (raw_o),
    .masked_o   (masked_o),
    .irq_o      (irq_o)
  );

  // R9
  irq_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o & enable_i) != '0) |-> irq_o);

  // R1
  first_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> (raw_o == '0));

endmodule

// File: tb/pin_event_detector_bench.sv
module pin_event_detector_bench;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0, dir_out = '0, sense = '0, both = '0, pol = '0, en = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_mask = '0;
  logic [N-1:0] raw, masked;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_event_detector #(.NUM_PINS(N)) u_pin_event_detector (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dir_out_i(dir_out),
    .sense_lvl_i(sense), .both_edge_i(both), .polarity_i(pol),
    .enable_i(en), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = '1;
    step();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: level-high config holding while reset is released
    sense = '1; pol = '1; pin = 8'hff; en = '1;
    @(negedge clk); @(negedge clk);
    check("R1 reset raw", raw, '0);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    check("R1 first cycle", raw, '0);
    step();
    check("R3 level after arm", raw, 8'hff);

    // Exhaustive sweep: mode bits x direction x previous x new value (R2-R5, R8, R9, R11)
    for (int c = 0; c < 64; c++) begin
      logic s, b, p, d, pv, cv, ev;
      logic [N-1:0] e, exp_raw;
      s = c[0]; b = c[1]; p = c[2]; d = c[3]; pv = c[4]; cv = c[5];
      sense = {N{s}}; both = {N{b}}; pol = {N{p}}; dir_out = {N{d}};
      e = 8'h5a ^ 8'(c * 37);
      en = e;
      pin = {N{pv}};
      step(); step();
      pin = {N{cv}};
      clr_we = 1'b1; clr_mask = '1;
      step();
      clr_we = 1'b0; clr_mask = '0;
      if (s) ev = (cv == p);
      else if (d) ev = 1'b0;
      else if (pv == cv) ev = 1'b0;
      else if (b) ev = 1'b1;
      else ev = p ? cv : !cv;
      exp_raw = {N{ev}};
      check(s ? "R3 level sweep" : (d ? "R2 output sweep" : (b ? "R4 both sweep" : "R5 edge sweep")),
            raw, exp_raw);
      check("R9 masked sweep", masked, exp_raw & e);
      check("R9 irq sweep", {7'b0, irq}, {7'b0, |(exp_raw & e)});
    end

    // R6: partial clear
    sense = '0; both = '1; dir_out = '0; en = '1;
    pin = '0; step(); clear_all();
    pin = 8'hff; step();
    check("R11 any-edge latched", raw, 8'hff);
    clr_we = 1'b1; clr_mask = 8'h0f; step(); clr_we = 1'b0;
    check("R6 partial clear", raw, 8'hf0);

    // R9: enable off hides raw
    en = 8'h00; @(negedge clk);
    check("R9 masked off", masked, 8'h00);
    check("R9 irq off", {7'b0, irq}, 8'h00);

    // R10: reconfigure without clearing
    sense = 8'h0f; pol = 8'h00; both = 8'h00; en = 8'h3c; step();
    check("R10 config kept", raw & 8'hf0, 8'hf0);
    check("R10 masked", masked, 8'h30);

    // R7: clear against held level
    clear_all();
    sense = '1; pol = '1; pin = 8'h01; clear_all();
    check("R7 clear while active", raw, 8'h01);
    pin = 8'h00; step();
    clear_all();
    check("R7 clear after inactive", raw, 8'h00);

    // R8: clear and edge on one bit together, other bits cleared
    sense = '0; both = '1; pin = 8'h00; step();
    pin = 8'h03; step();
    pin = 8'h02; clr_we = 1'b1; clr_mask = 8'h03; step(); clr_we = 1'b0;
    check("R8 event beats clear", raw, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule